// File: doc/BRIEF.md
# BCD Real-Time Clock Register Bank in a Byte RAM Space

This block keeps a calendar clock in packed BCD: seconds, minutes, hours, day of week, date, month, year and century. It occupies the eight highest byte addresses of a 17-bit byte-wide address space. Every lower address reaches a plain storage array. A host reaches both through active-low chip-enable, output-enable and write-enable strobes, all sampled on the rising clock edge. A single-cycle pulse on `tick_in` advances the time by one second. The carry from seconds ripples up through the minutes, hours, day of week, date, month, year and century.

The bank also holds control bits. One bit stops the clock. A write-freeze bit lets the host stage a full new time and commit it at once. A read-freeze bit gives a coherent snapshot to read while the clock keeps counting. A frequency-test bit toggles a pin on each accepted second. A battery-status bit mirrors an input pin. Bits of the clock bytes that carry no time data act as ordinary storage.

Read data returns one cycle after the request and is marked by `rvalid`. There is no ready signal and no back-pressure: the host must take the byte in the cycle `rvalid` is high. A request starts on every clock edge at which the strobes select it.

Top module: `rtc_regfile`

## Requirements
- R1: Addresses 0x1FFF8 to 0x1FFFF select, in rising order, century, seconds, minutes, hour, day of week, date, month and year. Every other address reaches the plain array, which decodes only the low RAM_AW address bits (default 10), so addresses that are equal in those bits alias.
- R2: A read request is ce_n=0, oe_n=0 and we_n=1 at a clock edge. Its byte appears on rdata with rvalid=1 during the following cycle. rvalid is 0 after any edge without a read request.
- R3: A write happens at any edge with ce_n=0 and we_n=0, whatever the level of oe_n. A write never raises rvalid.
- R4: After reset the time reads 00:00:00, day of week 1, date 01, month 01, year 00 and century 00. All control and storage bits of the clock bytes are 0, rvalid is 0 and ftest_out is 0.
- R5: Each tick_in pulse advances the seconds in BCD. 59 wraps to 00 and carries into the minutes. Minutes 59 wrap to 00 and carry into the hours. Hours 23 wrap to 00 and carry into both day of week (07 wraps to 01) and date.
- R6: The date wraps to 01 and carries into the month after 30 in April, June, September and November, and after 31 in the other long months. In February it wraps after 29 when the BCD year is divisible by four, and after 28 otherwise.
- R7: Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00 and carries into the century. Century 39 wraps to 00.
- R8: While seconds bit 7 (stop bit) is 1, tick pulses are ignored and no counter changes.
- R9: Century bit 7 is the write-freeze bit. Setting it copies the counters into a staging bank, and while it is 1 host writes to time fields go only to that bank. The counters keep counting and reads still show them. The write that clears the bit loads the whole staging bank, with that write's own field, into the counters at that edge.
- R10: Century bit 6 is the read-freeze bit. Setting it captures the counters at that edge, and while it is 1 reads of time fields return that capture while the counters keep advancing. Once it is cleared, reads show the live counters.
- R11: The non-time bits read back the last value written. These are minutes bit 7, hour bits 7-6, day bits 5-3, date bits 7-6, month bits 7-5, and the write-freeze, read-freeze, stop and frequency-test bits.
- R12: Day bit 7 always reads the level of the batt_flag pin, and host writes to it have no effect.
- R13: While day bit 6 is 1, ftest_out toggles on each accepted tick. While it is 0, ftest_out is 0 from the next edge on.
- R14: A tick that coincides with a host write into the counters is dropped. The written value is kept unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all strobes sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 17 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid when rvalid is 1 |
| rvalid | output | 1 | Read data valid, one cycle after a read request |
| tick_in | input | 1 | One-cycle pulse per elapsed second |
| batt_flag | input | 1 | Battery status shown in day bit 7 |
| ftest_out | output | 1 | Frequency-test toggle output |

## Verification
A wrong carry or month-length decision leaves a bad digit in a counter, and it shows on the next read of that byte. The bench therefore steps the clock over each wrap boundary and reads every field right after the tick. A staging bank or capture loaded at the wrong edge stays hidden until the freeze bit changes. For that reason the bench reads the seconds both while a freeze bit is set and straight after it is cleared. A stuck stop or test bit shows within one tick as seconds that failed to change or a pin that failed to toggle.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NREG = 8;

  typedef logic [NREG-1:0][7:0] rtc_bank_t;

  typedef enum logic [2:0] {
    IX_CEN  = 3'd0,
    IX_SEC  = 3'd1,
    IX_MIN  = 3'd2,
    IX_HR   = 3'd3,
    IX_DOW  = 3'd4,
    IX_DATE = 3'd5,
    IX_MON  = 3'd6,
    IX_YR   = 3'd7
  } rtc_idx_e;

  // bits of each clock byte that belong to the counters
  function automatic logic [7:0] time_mask(input logic [2:0] ix);
    case (ix)
      3'd0:    return 8'h3F;
      3'd1:    return 8'h7F;
      3'd2:    return 8'h7F;
      3'd3:    return 8'h3F;
      3'd4:    return 8'h07;
      3'd5:    return 8'h3F;
      3'd6:    return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  // BCD increment inside [lo, hi], wrapping to lo at or beyond hi
  function automatic logic [7:0] bcd_next(input logic [7:0] v,
                                          input logic [7:0] lo,
                                          input logic [7:0] hi);
    if (v >= hi)            return lo;
    else if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                     return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] mon,
                                            input logic [7:0] yr);
    logic [6:0] ybin;
    ybin = ({3'd0, yr[7:4]} * 7'd10) + {3'd0, yr[3:0]};
    case (mon)
      8'h02:                      return (ybin[1:0] == 2'd0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic rtc_bank_t bank_reset();
    rtc_bank_t b;
    b          = '0;
    b[IX_DOW]  = 8'h01;
    b[IX_DATE] = 8'h01;
    b[IX_MON]  = 8'h01;
    return b;
  endfunction
endpackage

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      adv,
  input  logic      load,
  input  rtc_bank_t load_val,
  output rtc_bank_t cur
);
  rtc_bank_t nxt;
  logic sec_wrap, min_wrap, hr_wrap, date_wrap, mon_wrap, yr_wrap;
  logic day_carry;

  always_comb begin
    nxt       = cur;
    sec_wrap  = cur[IX_SEC] >= 8'h59;
    min_wrap  = cur[IX_MIN] >= 8'h59;
    hr_wrap   = cur[IX_HR]  >= 8'h23;
    date_wrap = cur[IX_DATE] >= month_last(cur[IX_MON], cur[IX_YR]);
    mon_wrap  = cur[IX_MON] >= 8'h12;
    yr_wrap   = cur[IX_YR]  >= 8'h99;
    day_carry = sec_wrap && min_wrap && hr_wrap;

    nxt[IX_SEC] = bcd_next(cur[IX_SEC], 8'h00, 8'h59);
    if (sec_wrap)
      nxt[IX_MIN] = bcd_next(cur[IX_MIN], 8'h00, 8'h59);
    if (sec_wrap && min_wrap)
      nxt[IX_HR] = bcd_next(cur[IX_HR], 8'h00, 8'h23);
    if (day_carry) begin
      nxt[IX_DOW]  = bcd_next(cur[IX_DOW], 8'h01, 8'h07);
      nxt[IX_DATE] = bcd_next(cur[IX_DATE], 8'h01,
                              month_last(cur[IX_MON], cur[IX_YR]));
    end
    if (day_carry && date_wrap)
      nxt[IX_MON] = bcd_next(cur[IX_MON], 8'h01, 8'h12);
    if (day_carry && date_wrap && mon_wrap)
      nxt[IX_YR] = bcd_next(cur[IX_YR], 8'h00, 8'h99);
    if (day_carry && date_wrap && mon_wrap && yr_wrap)
      nxt[IX_CEN] = bcd_next(cur[IX_CEN], 8'h00, 8'h39);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    cur <= bank_reset();
    else if (load) cur <= load_val;
    else if (adv)  cur <= nxt;
  end
endmodule

// File: rtl/rtc_ram.sv
module rtc_ram #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int RAM_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              rvalid,
  input  logic              tick_in,
  input  logic              batt_flag,
  output logic              ftest_out
);
  localparam int IDX_W = $clog2(NREG);
  localparam logic [ADDR_W-IDX_W-1:0] TOP_PAGE = '1;

  logic [IDX_W-1:0] idx;
  logic sel_clk, wr_req, rd_req, clk_wr, ram_we;
  logic w_bit, r_bit, osc, ft_en, w_new, r_new;
  logic cal_load, tick_go;
  rtc_bank_t cal, hold, snap, ext, base, hold_nxt;
  logic [7:0] view_t, clk_byte, clk_q, ram_rdata;
  logic rd_clk_q, rvalid_q, ft_q;

  // address decode and bus strobes
  assign idx     = addr[IDX_W-1:0];
  assign sel_clk = (addr[ADDR_W-1:IDX_W] == TOP_PAGE);
  assign wr_req  = !ce_n && !we_n;
  assign rd_req  = !ce_n && !oe_n && we_n;
  assign clk_wr  = wr_req && sel_clk;
  assign ram_we  = wr_req && !sel_clk;

  // control bits
  assign w_bit = ext[IX_CEN][7];
  assign r_bit = ext[IX_CEN][6];
  assign osc   = ext[IX_SEC][7];
  assign ft_en = ext[IX_DOW][6];
  assign w_new = (clk_wr && idx == IX_CEN) ? wdata[7] : w_bit;
  assign r_new = (clk_wr && idx == IX_CEN) ? wdata[6] : r_bit;

  // write merge: staging bank while frozen, otherwise the live counters
  always_comb begin
    base     = w_bit ? hold : cal;
    hold_nxt = base;
    if (clk_wr) hold_nxt[idx] = wdata & time_mask(idx);
  end

  assign cal_load = clk_wr && !w_new;
  assign tick_go  = tick_in && !osc;

  rtc_calendar u_cal (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (tick_go),
    .load     (cal_load),
    .load_val (hold_nxt),
    .cur      (cal)
  );

  rtc_ram #(.AW(RAM_AW)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .addr  (addr[RAM_AW-1:0]),
    .wdata (wdata),
    .rdata (ram_rdata)
  );

  // storage and control bits; battery bit is never stored
  always_ff @(posedge clk) begin
    if (!rst_n) ext <= '0;
    else if (clk_wr)
      ext[idx] <= wdata & ~time_mask(idx) & ((idx == IX_DOW) ? 8'h7F : 8'hFF);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold <= bank_reset();
      snap <= bank_reset();
    end else begin
      if (clk_wr && w_new)  hold <= hold_nxt;
      if (!r_bit && r_new)  snap <= cal;
    end
  end

  // read path
  always_comb begin
    view_t   = r_bit ? snap[idx] : cal[idx];
    clk_byte = (view_t & time_mask(idx)) | ext[idx];
    if (idx == IX_DOW) clk_byte[7] = batt_flag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rd_clk_q <= 1'b0;
      clk_q    <= '0;
    end else begin
      rvalid_q <= rd_req;
      if (rd_req) begin
        rd_clk_q <= sel_clk;
        clk_q    <= clk_byte;
      end
    end
  end

  assign rvalid = rvalid_q;
  assign rdata  = rd_clk_q ? clk_q : ram_rdata;

  // frequency test output
  always_ff @(posedge clk) begin
    if (!rst_n || !ft_en) ft_q <= 1'b0;
    else if (tick_go)     ft_q <= ~ft_q;
  end

  assign ftest_out = ft_q;
endmodule

// File: rtl/rtc_regfile_chk.sv
module rtc_regfile_chk
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        rdata,
  input logic              rvalid,
  input logic              tick_in,
  input logic              batt_flag,
  input logic              ftest_out,
  input rtc_bank_t         cal,
  input logic              osc,
  input logic              ft_en,
  input logic              cal_load
);
  localparam logic [ADDR_W-1:0] DOW_ADDR = {{(ADDR_W-3){1'b1}}, 3'd4};

  AST_READ_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && we_n) |=> rvalid); // R2

  AST_VALID_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> $past(!ce_n && !oe_n && we_n)); // R2

  AST_WRITE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !we_n) |=> !rvalid); // R3

  AST_TICK_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_in && !osc && !cal_load) |=> (cal != $past(cal))); // R5

  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (osc && !cal_load) |=> $stable(cal)); // R8

  AST_BATT_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && $past(addr) == DOW_ADDR) |-> (rdata[7] == $past(batt_flag))); // R12

  AST_FT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ft_en |=> !ftest_out); // R13
endmodule

bind rtc_regfile rtc_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ce_n      (ce_n),
  .oe_n      (oe_n),
  .we_n      (we_n),
  .addr      (addr),
  .rdata     (rdata),
  .rvalid    (rvalid),
  .tick_in   (tick_in),
  .batt_flag (batt_flag),
  .ftest_out (ftest_out),
  .cal       (cal),
  .osc       (osc),
  .ft_en     (ft_en),
  .cal_load  (cal_load)
);

// File: tb/tb_rtc_regfile.sv
`timescale 1ns/1ps
module tb_rtc_regfile;
  localparam logic [16:0] A_CEN  = 17'h1FFF8;
  localparam logic [16:0] A_SEC  = 17'h1FFF9;
  localparam logic [16:0] A_MIN  = 17'h1FFFA;
  localparam logic [16:0] A_HR   = 17'h1FFFB;
  localparam logic [16:0] A_DOW  = 17'h1FFFC;
  localparam logic [16:0] A_DATE = 17'h1FFFD;
  localparam logic [16:0] A_MON  = 17'h1FFFE;
  localparam logic [16:0] A_YR   = 17'h1FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [16:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic rvalid;
  logic tick_in = 1'b0;
  logic batt_flag = 1'b0;
  logic ftest_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] exp_q [$];
  logic [7:0] msk_q [$];
  string      tag_q [$];

  always #2.5 clk = ~clk;

  rtc_regfile dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
    .tick_in(tick_in), .batt_flag(batt_flag), .ftest_out(ftest_out)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read bytes as rvalid appears
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected rvalid", rdata, 8'h00);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic logic [7:0] m = msk_q.pop_front();
        automatic string t = tag_q.pop_front();
        check((rdata & m) == (e & m), t, rdata & m, e & m);
      end
    end
  end

  task automatic wr(input logic [16:0] a, input logic [7:0] d,
                    input logic oe_lvl = 1'b1);
    @(negedge clk);
    addr = a; wdata = d; ce_n = 1'b0; we_n = 1'b0; oe_n = oe_lvl;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic rd(input logic [16:0] a, input logic [7:0] e,
                    input logic [7:0] m, input string t);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    exp_q.push_back(e); msk_q.push_back(m); tag_q.push_back(t);
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_in = 1'b1;
      @(negedge clk); tick_in = 1'b0;
    end
  endtask

  task automatic near_midnight();
    wr(A_SEC, 8'h59); wr(A_MIN, 8'h59); wr(A_HR, 8'h23);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog expired", 8'h00, 8'h00);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 reset state
    check(rvalid == 1'b0, "R4 rvalid after reset", {7'd0, rvalid}, 8'h00);
    check(ftest_out == 1'b0, "R4 ftest_out after reset", {7'd0, ftest_out}, 8'h00);
    rd(A_CEN,  8'h00, 8'hFF, "R4 century reset");
    rd(A_SEC,  8'h00, 8'hFF, "R4 seconds reset");
    rd(A_MIN,  8'h00, 8'hFF, "R4 minutes reset");
    rd(A_HR,   8'h00, 8'hFF, "R4 hour reset");
    rd(A_DOW,  8'h01, 8'hFF, "R4 day reset");
    rd(A_DATE, 8'h01, 8'hFF, "R4 date reset");
    rd(A_MON,  8'h01, 8'hFF, "R4 month reset");
    rd(A_YR,   8'h00, 8'hFF, "R4 year reset");

    // R1 plain array and aliasing
    wr(17'h00010, 8'hA5);
    wr(17'h1FFF7, 8'h3C);
    rd(17'h00010, 8'hA5, 8'hFF, "R1 ram byte");
    rd(17'h1FFF7, 8'h3C, 8'hFF, "R1 ram below clock page");
    rd(17'h003F7, 8'h3C, 8'hFF, "R1 ram alias low bits");

    // R5 simple advance
    wr(A_SEC, 8'h58);
    ticks(1);
    rd(A_SEC, 8'h59, 8'h7F, "R5 seconds 58->59");

    // R5 R7 full rollover
    wr(A_MIN, 8'h59); wr(A_HR, 8'h23); wr(A_DOW, 8'h07);
    wr(A_DATE, 8'h31); wr(A_MON, 8'h12); wr(A_YR, 8'h99);
    wr(A_CEN, 8'h39); wr(A_SEC, 8'h59);
    ticks(1);
    rd(A_SEC,  8'h00, 8'h7F, "R5 seconds wrap");
    rd(A_MIN,  8'h00, 8'h7F, "R5 minutes wrap");
    rd(A_HR,   8'h00, 8'h3F, "R5 hour wrap");
    rd(A_DOW,  8'h01, 8'h07, "R5 day-of-week wrap");
    rd(A_DATE, 8'h01, 8'h3F, "R6 date wrap in 31-day month");
    rd(A_MON,  8'h01, 8'h1F, "R7 month wrap");
    rd(A_YR,   8'h00, 8'hFF, "R7 year wrap");
    rd(A_CEN,  8'h00, 8'h3F, "R7 century wrap 39->00");

    // R6 February, non-leap
    wr(A_YR, 8'h23); wr(A_MON, 8'h02); wr(A_DATE, 8'h28);
    near_midnight(); ticks(1);
    rd(A_DATE, 8'h01, 8'h3F, "R6 non-leap Feb 28 wraps");
    rd(A_MON,  8'h03, 8'h1F, "R6 non-leap month carry");
    // R6 February, leap
    wr(A_YR, 8'h24); wr(A_MON, 8'h02); wr(A_DATE, 8'h28);
    near_midnight(); ticks(1);
    rd(A_DATE, 8'h29, 8'h3F, "R6 leap Feb 28 -> 29");
    rd(A_MON,  8'h02, 8'h1F, "R6 leap month held");
    // R6 30-day month
    wr(A_MON, 8'h04); wr(A_DATE, 8'h30);
    near_midnight(); ticks(1);
    rd(A_DATE, 8'h01, 8'h3F, "R6 April 30 wraps");
    rd(A_MON,  8'h05, 8'h1F, "R6 April carry");

    // R8 stop bit
    wr(A_SEC, 8'h90);
    ticks(3);
    rd(A_SEC, 8'h90, 8'hFF, "R8 stopped clock ignores ticks");
    wr(A_SEC, 8'h10);
    ticks(1);
    rd(A_SEC, 8'h11, 8'hFF, "R8 runs after stop cleared");

    // R9 write freeze
    wr(A_SEC, 8'h00); wr(A_MIN, 8'h00);
    wr(A_CEN, 8'hA0);
    wr(A_SEC, 8'h45); wr(A_MIN, 8'h30);
    rd(A_SEC, 8'h00, 8'h7F, "R9 staged write not visible");
    ticks(2);
    rd(A_SEC, 8'h02, 8'h7F, "R9 counters run while frozen");
    wr(A_CEN, 8'h21);
    rd(A_SEC, 8'h45, 8'h7F, "R9 seconds loaded on release");
    rd(A_MIN, 8'h30, 8'h7F, "R9 minutes loaded on release");
    rd(A_CEN, 8'h21, 8'hFF, "R9 century from release write");

    // R10 read freeze
    wr(A_CEN, 8'h61);
    ticks(3);
    rd(A_SEC, 8'h45, 8'h7F, "R10 snapshot held");
    rd(A_CEN, 8'h61, 8'hFF, "R11 freeze bits read back");
    wr(A_CEN, 8'h21);
    rd(A_SEC, 8'h48, 8'h7F, "R10 live after release");

    // R13 frequency test
    wr(A_DOW, 8'h42);
    check(ftest_out == 1'b0, "R13 idle before tick", {7'd0, ftest_out}, 8'h00);
    ticks(1);
    check(ftest_out == 1'b1, "R13 toggle 1", {7'd0, ftest_out}, 8'h01);
    ticks(1);
    check(ftest_out == 1'b0, "R13 toggle 2", {7'd0, ftest_out}, 8'h00);
    ticks(1);
    check(ftest_out == 1'b1, "R13 toggle 3", {7'd0, ftest_out}, 8'h01);
    wr(A_DOW, 8'h02);
    @(negedge clk);
    check(ftest_out == 1'b0, "R13 cleared when bit off", {7'd0, ftest_out}, 8'h00);

    // R12 battery flag
    batt_flag = 1'b1;
    rd(A_DOW, 8'h80, 8'h80, "R12 battery bit follows pin high");
    wr(A_DOW, 8'h00);
    rd(A_DOW, 8'h80, 8'h80, "R12 write does not clear battery bit");
    batt_flag = 1'b0;
    rd(A_DOW, 8'h00, 8'h80, "R12 battery bit follows pin low");

    // R11 general storage bits
    wr(A_MIN, 8'h85);  rd(A_MIN,  8'h85, 8'hFF, "R11 minutes bit 7");
    wr(A_HR, 8'hD2);   rd(A_HR,   8'hD2, 8'hFF, "R11 hour bits 7-6");
    wr(A_DOW, 8'h3B);  rd(A_DOW,  8'h3B, 8'hFF, "R11 day bits 5-3");
    wr(A_DATE, 8'hD5); rd(A_DATE, 8'hD5, 8'hFF, "R11 date bits 7-6");
    wr(A_MON, 8'hE7);  rd(A_MON,  8'hE7, 8'hFF, "R11 month bits 7-5");

    // R3 write with output enable active
    wr(A_SEC, 8'h12, 1'b0);
    rd(A_SEC, 8'h12, 8'h7F, "R3 write with oe_n low");

    // R14 tick coinciding with write
    @(negedge clk);
    addr = A_SEC; wdata = 8'h30; ce_n = 1'b0; we_n = 1'b0; tick_in = 1'b1;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; tick_in = 1'b0;
    rd(A_SEC, 8'h30, 8'h7F, "R14 write wins over tick");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R2 all reads answered",
          8'(exp_q.size()), 8'h00);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule